// File: doc/BRIEF.md
# Interrupt Shadow Register Stack

This block keeps a single shadow copy of three core CPU registers: the status flags, the working accumulator and the bank select register. When the processor vectors to an interrupt of either priority, the block captures the live values of all three. It also captures them when a subroutine call is issued with the fast option. When a return is issued with the fast option, the block presents the shadow contents together with a restore enable, and the register file loads them back into the working registers. A return without the fast option leaves the shadow and the working registers alone.

The shadow has no depth and no software access path. A high-priority interrupt taken while a low-priority handler is still running replaces the values that the low-priority entry saved. The block tracks which handlers are pending so that it can raise a one-cycle `overwrite_nested` pulse whenever this loss happens.

Top module: `fastret_shadow`

## Requirements
- R1: After a synchronous active-high reset the shadow holds zero in all three fields, `restore_en` is 0 and `overwrite_nested` is 0.
- R2: At a clock edge where `vec_strobe` is 1, whatever the value of `vec_hi` (1 = high priority, 0 = low priority), the shadow loads `live_status`, `live_acc` and `live_bank`.
- R3: At a clock edge where `fcall_strobe` is 1, the shadow loads the three live values.
- R4: While `fret_strobe` is 1, `restore_en` is 1 and the restore outputs carry the shadow contents in the same cycle. While `fret_strobe` is 0, `restore_en` is 0 and all restore outputs are zero.
- R5: A plain return (`pret_strobe` = 1, `fret_strobe` = 0) gives no restore, and the shadow contents are unchanged.
- R6: In cycles with no capture the shadow holds its value, whatever the live inputs do.
- R7: If a capture and `fret_strobe` occur in the same cycle, the restore outputs show the old shadow contents, and the new capture is stored at that edge.
- R8: A high-priority vector taken while a low-priority handler is pending replaces the shadow, and a following fast return gives the high-priority values.
- R9: `overwrite_nested` is 1 for exactly the cycle after an edge where a high-priority vector occurred while a low-priority handler was pending. A low vector marks a low handler as pending. Any return (fast or plain) clears the high-pending mark if it is set, and otherwise clears the low-pending mark.
- R10: A high-priority vector with no low handler pending, or a low-priority vector while a high handler is pending, does not raise `overwrite_nested`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| live_status | input | 5 | Current status flags |
| live_acc | input | 8 | Current working accumulator |
| live_bank | input | 4 | Current bank select |
| vec_strobe | input | 1 | Processor vectors to an interrupt this cycle |
| vec_hi | input | 1 | Priority of the vector: 1 high, 0 low |
| fcall_strobe | input | 1 | Subroutine call with fast option |
| fret_strobe | input | 1 | Return with fast option |
| pret_strobe | input | 1 | Return without fast option |
| rest_status | output | 5 | Status value to restore |
| rest_acc | output | 8 | Accumulator value to restore |
| rest_bank | output | 4 | Bank select value to restore |
| restore_en | output | 1 | Register file should load the restore values |
| overwrite_nested | output | 1 | Pulse: low-priority saved values were lost |

## Verification
The bench targets the same-cycle case where a capture and a fast return coincide. A design that forwarded the new capture would restore the wrong context, and one that dropped the capture would restore stale values on the next return. It nests a high vector inside a low one and checks both the restored values and the single-cycle loss pulse. A tracker that never cleared the pending marks would flag later unrelated high vectors, and one that flagged low-inside-high would pulse when nothing was lost. It also makes plain returns and changes the live inputs between captures, so that a shadow which loads freely shows up on the next fast return.

// File: rtl/shadow_pkg.sv
package shadow_pkg;
    parameter int STAT_W = 5;
    parameter int ACC_W  = 8;
    parameter int BANK_W = 4;

    typedef struct packed {
        logic [STAT_W-1:0] status;
        logic [ACC_W-1:0]  acc;
        logic [BANK_W-1:0] bank;
    } ctx_t;

    localparam int CTX_W = $bits(ctx_t);

    typedef enum logic [1:0] {
        CAP_NONE = 2'd0,
        CAP_LO   = 2'd1,
        CAP_HI   = 2'd2,
        CAP_CALL = 2'd3
    } cap_kind_e;

    function automatic cap_kind_e classify_cap(input logic vec, input logic hi,
                                               input logic call);
        if (vec)       return hi ? CAP_HI : CAP_LO;
        else if (call) return CAP_CALL;
        else           return CAP_NONE;
    endfunction
endpackage

// File: rtl/shadow_slot.sv
module shadow_slot
    import shadow_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cap_en,
    input  ctx_t cap_d,
    output ctx_t slot_q
);
    always_ff @(posedge clk) begin
        if (rst)         slot_q <= '0;
        else if (cap_en) slot_q <= cap_d;
    end

    assert_capture_loads_R2: assert property (@(posedge clk) disable iff (rst)
        cap_en |=> slot_q == $past(cap_d));

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !cap_en |=> $stable(slot_q));
endmodule

// File: rtl/nest_tracker.sv
module nest_tracker
    import shadow_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  cap_kind_e kind,
    input  logic      ret_any,
    output logic      overwrite_q
);
    logic lo_pend, hi_pend;
    logic lo_pend_n, hi_pend_n, flag_n;

    always_comb begin
        lo_pend_n = lo_pend;
        hi_pend_n = hi_pend;
        if (ret_any) begin
            if (hi_pend) hi_pend_n = 1'b0;
            else         lo_pend_n = 1'b0;
        end
        if (kind == CAP_LO) lo_pend_n = 1'b1;
        if (kind == CAP_HI) hi_pend_n = 1'b1;
        flag_n = (kind == CAP_HI) && lo_pend;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_pend     <= 1'b0;
            hi_pend     <= 1'b0;
            overwrite_q <= 1'b0;
        end else begin
            lo_pend     <= lo_pend_n;
            hi_pend     <= hi_pend_n;
            overwrite_q <= flag_n;
        end
    end

    assert_flag_needs_hi_R9: assert property (@(posedge clk) disable iff (rst)
        overwrite_q |-> $past(kind == CAP_HI));

    assert_no_flag_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (kind != CAP_HI) |=> !overwrite_q);
endmodule

// File: rtl/restore_mux.sv
module restore_mux
    import shadow_pkg::*;
(
    input  logic fret,
    input  ctx_t slot_q,
    output ctx_t rest,
    output logic en
);
    always_comb begin
        en   = fret;
        rest = fret ? slot_q : '0;
    end

    always_comb begin
        assert_quiet_R4: assert (fret || rest == '0);
    end
endmodule

// File: rtl/fastret_shadow.sv
module fastret_shadow
    import shadow_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [STAT_W-1:0] live_status,
    input  logic [ACC_W-1:0]  live_acc,
    input  logic [BANK_W-1:0] live_bank,
    input  logic              vec_strobe,
    input  logic              vec_hi,
    input  logic              fcall_strobe,
    input  logic              fret_strobe,
    input  logic              pret_strobe,
    output logic [STAT_W-1:0] rest_status,
    output logic [ACC_W-1:0]  rest_acc,
    output logic [BANK_W-1:0] rest_bank,
    output logic              restore_en,
    output logic              overwrite_nested
);
    ctx_t      live_ctx, slot_q, rest_ctx;
    cap_kind_e kind;

    assign live_ctx = '{status: live_status, acc: live_acc, bank: live_bank};
    assign kind     = classify_cap(vec_strobe, vec_hi, fcall_strobe);

    shadow_slot u_slot (
        .clk    (clk),
        .rst    (rst),
        .cap_en (kind != CAP_NONE),
        .cap_d  (live_ctx),
        .slot_q (slot_q)
    );

    nest_tracker u_nest (
        .clk         (clk),
        .rst         (rst),
        .kind        (kind),
        .ret_any     (fret_strobe | pret_strobe),
        .overwrite_q (overwrite_nested)
    );

    restore_mux u_mux (
        .fret   (fret_strobe),
        .slot_q (slot_q),
        .rest   (rest_ctx),
        .en     (restore_en)
    );

    assign rest_status = rest_ctx.status;
    assign rest_acc    = rest_ctx.acc;
    assign rest_bank   = rest_ctx.bank;

    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) |-> (slot_q == '0) && !overwrite_nested);

    assert_fret_old_value_R7: assert property (@(posedge clk) disable iff (rst)
        (fret_strobe && kind != CAP_NONE) |=> slot_q == $past(live_ctx));

    assert_plain_ret_R5: assert property (@(posedge clk) disable iff (rst)
        (pret_strobe && !fret_strobe) |-> !restore_en);
endmodule

// File: tb/fastret_shadow_bench.sv
module fastret_shadow_bench;
    logic       clk = 0;
    logic       rst;
    logic [4:0] live_status;
    logic [7:0] live_acc;
    logic [3:0] live_bank;
    logic       vec_strobe, vec_hi, fcall_strobe, fret_strobe, pret_strobe;
    logic [4:0] rest_status;
    logic [7:0] rest_acc;
    logic [3:0] rest_bank;
    logic       restore_en, overwrite_nested;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    fastret_shadow u_fastret_shadow (
        .clk(clk), .rst(rst),
        .live_status(live_status), .live_acc(live_acc), .live_bank(live_bank),
        .vec_strobe(vec_strobe), .vec_hi(vec_hi), .fcall_strobe(fcall_strobe),
        .fret_strobe(fret_strobe), .pret_strobe(pret_strobe),
        .rest_status(rest_status), .rest_acc(rest_acc), .rest_bank(rest_bank),
        .restore_en(restore_en), .overwrite_nested(overwrite_nested)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        vec_strobe = 0; vec_hi = 0; fcall_strobe = 0;
        fret_strobe = 0; pret_strobe = 0;
    endtask

    task automatic set_live(input logic [4:0] s, input logic [7:0] a, input logic [3:0] b);
        live_status = s; live_acc = a; live_bank = b;
    endtask

    task automatic chk1(input string req, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic chk_rest(input string req, input logic en,
                            input logic [4:0] s, input logic [7:0] a, input logic [3:0] b);
        tests++;
        if (restore_en !== en || rest_status !== s || rest_acc !== a || rest_bank !== b) begin
            fails++;
            $display("FAIL %s: got en=%0b %h/%h/%h expected en=%0b %h/%h/%h", req,
                     restore_en, rest_status, rest_acc, rest_bank, en, s, a, b);
        end
    endtask

    // fast return: check restore in the same cycle, then clock it
    task automatic fast_ret(input string req, input logic [4:0] s,
                            input logic [7:0] a, input logic [3:0] b);
        idle();
        fret_strobe = 1;
        #1 chk_rest(req, 1'b1, s, a, b);
        tick();
        idle();
    endtask

    task automatic do_reset();
        idle();
        set_live(5'h1F, 8'hFF, 4'hF);
        rst = 1;
        tick(); tick();
        rst = 0;
    endtask

    task automatic t_reset();
        do_reset();
        chk1("R1 overwrite_nested", overwrite_nested, 1'b0);
        chk_rest("R1/R4 idle outputs zero", 1'b0, 5'h0, 8'h0, 4'h0);
        fast_ret("R1 shadow zero", 5'h0, 8'h0, 4'h0);
    endtask

    task automatic t_vector_capture();
        do_reset();
        set_live(5'h15, 8'hA5, 4'h3);
        vec_strobe = 1; vec_hi = 0;
        tick(); idle();
        set_live(5'h02, 8'h11, 4'h9);
        #1 chk_rest("R4 no fret zero", 1'b0, 5'h0, 8'h0, 4'h0);
        tick();
        fast_ret("R2 low vector capture / R6 hold", 5'h15, 8'hA5, 4'h3);
        set_live(5'h0A, 8'h5C, 4'hE);
        vec_strobe = 1; vec_hi = 1;
        tick(); idle();
        set_live(5'h00, 8'h00, 4'h0);
        fast_ret("R2 high vector capture", 5'h0A, 8'h5C, 4'hE);
    endtask

    task automatic t_fast_call();
        do_reset();
        set_live(5'h07, 8'h3C, 4'h6);
        fcall_strobe = 1;
        tick(); idle();
        set_live(5'h18, 8'hC3, 4'h1);
        tick(); tick();
        fast_ret("R3 fast call capture", 5'h07, 8'h3C, 4'h6);
    endtask

    task automatic t_plain_ret();
        do_reset();
        set_live(5'h13, 8'h77, 4'hB);
        fcall_strobe = 1;
        tick(); idle();
        set_live(5'h01, 8'h88, 4'h2);
        pret_strobe = 1;
        #1 chk1("R5 plain return no restore_en", restore_en, 1'b0);
        chk_rest("R5 plain return outputs", 1'b0, 5'h0, 8'h0, 4'h0);
        tick(); idle();
        fast_ret("R5 shadow unchanged by plain return", 5'h13, 8'h77, 4'hB);
    endtask

    task automatic t_same_cycle();
        do_reset();
        set_live(5'h05, 8'h21, 4'h4);
        fcall_strobe = 1;
        tick(); idle();
        set_live(5'h1A, 8'hE7, 4'hC);
        fcall_strobe = 1; fret_strobe = 1;
        #1 chk_rest("R7 same-cycle restore uses old", 1'b1, 5'h05, 8'h21, 4'h4);
        tick(); idle();
        fast_ret("R7 same-cycle capture stored", 5'h1A, 8'hE7, 4'hC);
    endtask

    task automatic t_nested();
        do_reset();
        set_live(5'h11, 8'h22, 4'h3);
        vec_strobe = 1; vec_hi = 0;
        tick(); idle();
        chk1("R10 low vector no flag", overwrite_nested, 1'b0);
        set_live(5'h0E, 8'h99, 4'hD);
        vec_strobe = 1; vec_hi = 1;
        tick(); idle();
        chk1("R9 nested high raises flag", overwrite_nested, 1'b1);
        tick();
        chk1("R9 flag is one cycle", overwrite_nested, 1'b0);
        fast_ret("R8 nested high overwrote low", 5'h0E, 8'h99, 4'hD);
        pret_strobe = 1;            // ends low handler
        tick(); idle();
        vec_strobe = 1; vec_hi = 1;
        tick(); idle();
        chk1("R10 high with no low pending", overwrite_nested, 1'b0);
        vec_strobe = 1; vec_hi = 0; // low while high pending
        tick(); idle();
        chk1("R10 low inside high no flag", overwrite_nested, 1'b0);
        tick();
        chk1("R10 still quiet", overwrite_nested, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst = 1;
        idle();
        set_live(5'h0, 8'h0, 4'h0);
        @(negedge clk);
        t_reset();
        t_vector_capture();
        t_fast_call();
        t_plain_ret();
        t_same_cycle();
        t_nested();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule